// File: doc/BRIEF.md
# ADC Offset Calibration Sequencer

This block sits behind the decimation filter of a two-channel 24-bit audio converter. It runs a start-up calibration. When reset is released it counts frames. It lets the first frames pass unused so the upstream filters can settle. It then sums a fixed number of samples on each channel and keeps the mean of each channel as that channel's DC offset. From then on, every sample has its channel's offset subtracted, and the result is clamped to the 24-bit full-scale codes.

While calibration runs, a busy flag stays high. Corrected data is held back until a fixed frame count after reset release, and that count depends on whether the serial interface runs as clock master or as slave. A calibration-source select passes through the block to the external input mux, which chooses between the common-mode reference and the live inputs. The block itself treats whatever samples arrive as the measurement.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst` is high, `cal_busy` is 1, `out_valid` is 0 and both outputs are zero. Calibration starts on the first clock with `rst` low.
- R2: `cal_busy` falls on the 8704th `frame_stb` after reset release and stays low until the next reset.
- R3: A sample (an `in_valid` cycle) belongs to frame n, where n is the number of `frame_stb` pulses seen since reset release. Samples of frames 0 to 512 do not affect the offset.
- R4: The samples of frames 513 to 8704 (8192 per channel) are summed in signed form, separately for each channel. Each channel's offset is the sum shifted arithmetically right by 13, which is the mean rounded toward minus infinity.
- R5: Once released, each output equals its input minus that channel's offset, saturated to 7FFFFF hex above full scale and to 800000 hex below it.
- R6: With `slave_mode`=0, the first corrected output comes from the sample of frame 8960. With `slave_mode`=1 it comes from frame 8961, and the sample of frame 8960 gives no output.
- R7: Before release, `out_valid` stays 0 and both outputs are zero.
- R8: `src_sel_out` equals `src_sel_in` delayed by one clock.
- R9: Asserting `rst` in the middle of calibration discards the partial sums. The offset of the next complete cycle depends only on that cycle's samples.
- R10: `out_valid` and the corrected data appear one clock after the `in_valid` cycle that carried the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset. Its release starts a calibration |
| frame_stb | input | 1 | One-cycle pulse per stereo frame |
| slave_mode | input | 1 | 1 when the serial interface is slave (release one frame later) |
| src_sel_in | input | 1 | Calibration source: 0 common-mode reference, 1 live inputs |
| in_valid | input | 1 | Sample pair on `in_left`/`in_right` is valid |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| src_sel_out | output | 1 | Registered copy of `src_sel_in` for the input mux |
| cal_busy | output | 1 | High during reset and calibration |
| out_valid | output | 1 | Corrected sample pair is valid |
| out_left | output | 24 | Corrected left sample |
| out_right | output | 24 | Corrected right sample |

## Verification
The assertions check on every cycle that busy is high after reset and never rises again without reset, and that no valid output appears while busy. They also check that idle outputs are zero, that the select is forwarded with one cycle of delay, that a stored offset changes only when a sum completes, and that a positive sample minus a negative offset never yields a negative result. Only the bench scenarios can show the exact frame on which busy falls, the frame on which output is released in each mode, the value of the mean and its floor rounding, the exact saturation edges, and that an aborted calibration leaves nothing in the next sum.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    PH_SETTLE,
    PH_ACCUM,
    PH_HOLD,
    PH_RUN
  } phase_t;
endpackage

// File: rtl/cal_frame_seq.sv
module cal_frame_seq
  import cal_pkg::*;
#(
  parameter int DISCARD     = 512,
  parameter int ACC_LOG2    = 13,
  parameter int REL_FRAMES  = 8960,
  parameter int SLAVE_EXTRA = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic in_valid,
  input  logic slave_mode,
  output logic cal_busy,
  output logic acc_en,
  output logic acc_last,
  output logic released
);
  localparam int CAL_FRAMES = DISCARD + (1 << ACC_LOG2);
  localparam int REL_MAX    = REL_FRAMES + SLAVE_EXTRA;
  localparam int CW         = $clog2(REL_MAX + 1);
  localparam int SW         = ACC_LOG2 + 1;

  logic [CW-1:0] frm_cnt;
  logic [SW-1:0] smp_cnt;
  logic          cal_ok;
  logic [CW-1:0] rel_thr;
  phase_t        phase;

  assign rel_thr = slave_mode ? CW'(REL_MAX) : CW'(REL_FRAMES);

  always_comb begin
    if (cal_ok)
      phase = (frm_cnt >= rel_thr) ? PH_RUN : PH_HOLD;
    else if (frm_cnt > CW'(DISCARD))
      phase = PH_ACCUM;
    else
      phase = PH_SETTLE;
  end

  assign acc_en   = in_valid && (phase == PH_ACCUM);
  assign acc_last = acc_en && (smp_cnt == SW'((1 << ACC_LOG2) - 1));
  assign released = (phase == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_cnt  <= '0;
      smp_cnt  <= '0;
      cal_ok   <= 1'b0;
      cal_busy <= 1'b1;
    end else begin
      if (frame_stb && frm_cnt != CW'(REL_MAX))
        frm_cnt <= frm_cnt + 1'b1;
      if (frame_stb && frm_cnt == CW'(CAL_FRAMES - 1))
        cal_busy <= 1'b0;
      if (acc_en)
        smp_cnt <= smp_cnt + 1'b1;
      if (acc_last)
        cal_ok <= 1'b1;
    end
  end

  // R1: busy is raised by reset
  p_busy_after_reset_r1: assert property (@(posedge clk) rst |=> cal_busy);
  // R2: once low, busy stays low until the next reset
  p_busy_no_rise_r2: assert property (@(posedge clk) disable iff (rst)
    !cal_busy |=> !cal_busy);
  // R6: release never overlaps calibration
  p_release_after_cal_r6: assert property (@(posedge clk) disable iff (rst)
    released |-> !cal_busy);
endmodule

// File: rtl/cal_chan_acc.sv
module cal_chan_acc #(
  parameter int DW       = 24,
  parameter int ACC_LOG2 = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_last,
  input  logic [DW-1:0] sample,
  output logic [DW-1:0] offset
);
  localparam int AW = DW + ACC_LOG2;

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_nx;
  logic        [DW-1:0] off_q = '0;

  assign acc_nx = acc_q + $signed({{ACC_LOG2{sample[DW-1]}}, sample});
  assign offset = off_q;

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (acc_last)
      acc_q <= '0;
    else if (acc_en)
      acc_q <= acc_nx;
  end

  // offset survives reset; only a completed sum replaces it
  always_ff @(posedge clk) begin
    if (acc_last && !rst)
      off_q <= acc_nx[AW-1:ACC_LOG2];
  end

  // R9: stored offset changes only when a full sum completes
  p_off_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_last |=> $stable(off_q));
endmodule

// File: rtl/cal_correct.sv
module cal_correct #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] offset,
  output logic [DW-1:0] result
);
  localparam int EW = DW + 1;
  localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

  logic [EW-1:0] diff;
  logic [DW-1:0] clamped;

  assign diff = {sample[DW-1], sample} - {offset[DW-1], offset};

  always_comb begin
    if (diff[EW-1] != diff[EW-2])
      clamped = diff[EW-1] ? NEG_FS : POS_FS;
    else
      clamped = diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      result <= '0;
    else
      result <= en ? clamped : '0;
  end

  // R5: non-negative sample minus negative offset cannot come out negative
  p_sign_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !sample[DW-1] && offset[DW-1]) |=> !result[DW-1]);
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import cal_pkg::*;
#(
  parameter int DW          = 24,
  parameter int DISCARD     = 512,
  parameter int ACC_LOG2    = 13,
  parameter int REL_FRAMES  = 8960,
  parameter int SLAVE_EXTRA = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_stb,
  input  logic          slave_mode,
  input  logic          src_sel_in,
  input  logic          in_valid,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          src_sel_out,
  output logic          cal_busy,
  output logic          out_valid,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right
);
  logic acc_en, acc_last, released;
  logic [DW-1:0] smp  [NCH];
  logic [DW-1:0] offs [NCH];
  logic [DW-1:0] res  [NCH];

  assign smp[0]    = in_left;
  assign smp[1]    = in_right;
  assign out_left  = res[0];
  assign out_right = res[1];

  cal_frame_seq #(
    .DISCARD    (DISCARD),
    .ACC_LOG2   (ACC_LOG2),
    .REL_FRAMES (REL_FRAMES),
    .SLAVE_EXTRA(SLAVE_EXTRA)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .in_valid  (in_valid),
    .slave_mode(slave_mode),
    .cal_busy  (cal_busy),
    .acc_en    (acc_en),
    .acc_last  (acc_last),
    .released  (released)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    cal_chan_acc #(.DW(DW), .ACC_LOG2(ACC_LOG2)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .acc_en  (acc_en),
      .acc_last(acc_last),
      .sample  (smp[ch]),
      .offset  (offs[ch])
    );

    cal_correct #(.DW(DW)) u_cor (
      .clk   (clk),
      .rst   (rst),
      .en    (released && in_valid),
      .sample(smp[ch]),
      .offset(offs[ch]),
      .result(res[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      out_valid <= 1'b0;
    else
      out_valid <= released && in_valid;
  end

  always_ff @(posedge clk) begin
    src_sel_out <= src_sel_in;
  end

  // R7: outputs are zero whenever no valid pair is presented
  p_zero_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_left == '0 && out_right == '0));
  // R6: no corrected data while calibration is running
  p_no_valid_busy_r6: assert property (@(posedge clk) disable iff (rst)
    cal_busy |-> !out_valid);
  // R8: select is forwarded one clock later
  p_sel_forward_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (src_sel_out == $past(src_sel_in)));
  // R10: a valid output always follows a valid input
  p_valid_latency_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/tb_offset_cal_seq.sv
`timescale 1ns/1ps
module tb_offset_cal_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_stb = 1'b0;
  logic        slave_mode = 1'b0;
  logic        src_sel_in = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        src_sel_out, cal_busy, out_valid;
  logic [23:0] out_left, out_right;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic        got_v;
  logic [23:0] got_l, got_r;

  always #2.5 clk = ~clk;

  offset_cal_seq dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .slave_mode(slave_mode),
    .src_sel_in(src_sel_in), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .src_sel_out(src_sel_out), .cal_busy(cal_busy),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  // {in_left, in_right, exp_left, exp_right}; offsets are +1000 / -2000
  localparam logic [95:0] VEC [0:7] = '{
    {24'h000000, 24'h000000, 24'hFFFC18, 24'h0007D0},
    {24'h0003E8, 24'hFFF830, 24'h000000, 24'h000000},
    {24'h800000, 24'h7FFFFF, 24'h800000, 24'h7FFFFF},
    {24'h8003E8, 24'h7FF82F, 24'h800000, 24'h7FFFFF},
    {24'h8003E7, 24'h7FF830, 24'h800000, 24'h7FFFFF},
    {24'h7FFFFF, 24'h800000, 24'h7FFC17, 24'h8007D0},
    {24'h123456, 24'hFEDCBA, 24'h12306E, 24'hFEE48A},
    {24'hFFFFFF, 24'h000001, 24'hFFFC17, 24'h0007D1}
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk) frame_stb = 1'b1;
    @(negedge clk) begin
      frame_stb = 1'b0;
      in_valid  = 1'b1;
      in_left   = l;
      in_right  = r;
    end
    @(negedge clk) begin
      in_valid = 1'b0;
      got_v = out_valid;
      got_l = out_left;
      got_r = out_right;
    end
    @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint sum_l, sum_r;
    logic signed [23:0] vl, vr;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 busy", {23'd0, cal_busy}, 24'd1);
    check("R1 valid", {23'd0, out_valid}, 24'd0);
    check("R1 left", out_left, 24'd0);
    // R8: select forwarding
    src_sel_in = 1'b1;
    @(negedge clk);
    check("R8 sel high", {23'd0, src_sel_out}, 24'd1);
    src_sel_in = 1'b0;
    @(negedge clk);
    check("R8 sel low", {23'd0, src_sel_out}, 24'd0);

    // master-mode calibration
    rst = 1'b0;
    for (int n = 1; n <= 512; n++) frame(24'h400000, 24'h400000); // R3 discarded
    for (int n = 513; n <= 8704; n++) begin
      frame(24'd1000, 24'hFFF830);
      if (n == 600) check("R7 valid during cal", {23'd0, got_v}, 24'd0);
      if (n == 8703) check("R2 busy before end", {23'd0, cal_busy}, 24'd1);
      if (n == 8704) check("R2 busy fall", {23'd0, cal_busy}, 24'd0);
    end
    for (int n = 8705; n <= 8959; n++) frame(24'h0ABCDE, 24'h0ABCDE);
    check("R6 master frame 8959 not valid", {23'd0, got_v}, 24'd0);
    check("R7 zero before release", got_l, 24'd0);
    for (int i = 0; i < 8; i++) begin
      frame(VEC[i][95:72], VEC[i][71:48]);
      check("R6 R10 valid", {23'd0, got_v}, 24'd1);
      check("R3 R4 R5 left", got_l, VEC[i][47:24]);
      check("R3 R4 R5 right", got_r, VEC[i][23:0]);
    end
    check("R2 busy stays low", {23'd0, cal_busy}, 24'd0);

    // abort in the middle of a slave-mode calibration
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 busy on reset", {23'd0, cal_busy}, 24'd1);
    check("R1 valid on reset", {23'd0, out_valid}, 24'd0);
    check("R1 right on reset", out_right, 24'd0);
    rst = 1'b0;
    slave_mode = 1'b1;
    for (int n = 1; n <= 3000; n++) frame(24'h300000, 24'h300000);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;

    // full slave-mode calibration with a non-integer mean
    sum_l = 0;
    sum_r = 0;
    for (int n = 1; n <= 512; n++) frame(24'hFFFFF9, 24'hFFFFF9);
    for (int n = 513; n <= 8704; n++) begin
      vl = (n % 2 == 0) ? 24'sd5 : 24'sd6;
      vr = -vl;
      sum_l += longint'(vl);
      sum_r += longint'(vr);
      frame(vl, vr);
    end
    for (int n = 8705; n <= 8960; n++) frame(24'd100, 24'd100);
    check("R6 slave frame 8960 not valid", {23'd0, got_v}, 24'd0);
    frame(24'd100, 24'd100);
    check("R6 slave frame 8961 valid", {23'd0, got_v}, 24'd1);
    check("R4 R9 left floor mean", got_l, 24'(100 - (sum_l >>> 13)));
    check("R4 R9 right floor mean", got_r, 24'(100 - (sum_r >>> 13)));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule